// File: doc/BRIEF.md
# Data Value Compare Debug Unit

This block watches a stream of data storage accesses on a word-aligned bus and raises a debug event when the bytes moved match values programmed into one of its compare channels. There are two channels by default, and they are evaluated in parallel on the same access. Each channel has a compare word, a per-lane enable mask and a two-bit mode. A channel can only fire when the address-compare qualifier supplied for it on that access is also true. Each access is judged on its own. An instruction that splits into several accesses is presented as several accesses, and each one can raise its own event.

Two kinds of operation need special handling. A cache-line zeroing store is compared as if its data word were all zeros on every lane it strobes. A conditional store made without a reservation writes nothing, so it raises no event. A single control bit chooses how events are reported. In synchronous reporting, each channel has a pulse bit that is high in the same cycle as the matching access. In asynchronous reporting, each channel sets a sticky status bit that software clears by writing a one.

Top module: `dvc_unit`

## Requirements
- R1: A channel whose mode is 2'b00 never raises an event.
- R2: In mode 2'b01 (AND), a channel fires only when every lane set in its mask is strobed and the byte on that lane equals the matching byte of its compare word. Lane i is bits [8i+7:8i] of the data, of the compare word, and bit i of the mask and of the strobes.
- R3: In mode 2'b01, a mask of all zeros never fires.
- R4: In mode 2'b10 (OR), a channel fires when at least one lane is set in the mask, strobed, and equal to its compare byte.
- R5: In mode 2'b11 (AND-OR), lanes {0,1} and lanes {2,3} are each checked as a separate AND group, and the channel fires if either group passes. A group whose mask bits are both zero does not pass.
- R6: No event is raised when acc_valid is 0, or for a channel whose acc_addr_hit bit is 0.
- R7: When acc_zero is 1, each strobed lane is compared against 8'h00, whatever value is on acc_data.
- R8: An access with acc_wr=1, acc_cond=1 and acc_resv=0 raises no event on any channel. With acc_resv=1 it is evaluated normally.
- R9: When cfg_async=0, evt_now[i] is high in the same cycle as the matching access, and stat is left unchanged.
- R10: When cfg_async=1, evt_now stays 0, and a match sets stat[i] at the next clock edge. That bit then stays set until it is cleared.
- R11: Writing stat_clr[i]=1 clears stat[i] at the next edge. If a new asynchronous match on channel i occurs in the same cycle as the clear, the bit ends up set.
- R12: The channels are independent. One access can fire any subset of them, and back-to-back accesses each produce their own event.
- R13: After reset, stat is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_wr | input | 1 | 1 = store, 0 = load |
| acc_zero | input | 1 | Access is a cache-line zeroing store beat |
| acc_cond | input | 1 | Access is a conditional store |
| acc_resv | input | 1 | Reservation held for the conditional store |
| acc_strb | input | 4 | Byte lanes accessed |
| acc_data | input | 32 | Data moved on the bus |
| acc_addr_hit | input | 2 | Address-compare qualifier, one bit per channel |
| cfg_mode | input | 4 | Mode per channel, channel i at bits [2i+1:2i] |
| cfg_ben | input | 8 | Lane enable mask per channel, channel i at bits [4i+3:4i] |
| cfg_val | input | 64 | Compare word per channel, channel i at bits [32i+31:32i] |
| cfg_async | input | 1 | 0 = synchronous pulse, 1 = sticky status |
| stat_clr | input | 2 | Write-one-to-clear for each status bit |
| evt_now | output | 2 | Synchronous event pulse, one bit per channel |
| stat | output | 2 | Sticky asynchronous event status |

## Verification
The compare and mode logic has no internal state, so a fault in a lane match or in the mode decode shows on evt_now in the same cycle as the access. Each table vector is built so that exactly one lane, group or qualifier decides its expected value. A corrupted status register shows on stat one edge after the access that set or cleared it. The checks cover a bit that is lost while no clear is pending, a bit that survives a clear, and a clear that wrongly wins over a new match in the same cycle.

// File: rtl/dvc_pkg.sv
package dvc_pkg;
    typedef enum logic [1:0] {
        CMP_OFF   = 2'b00,
        CMP_ALL   = 2'b01,
        CMP_ANY   = 2'b10,
        CMP_PAIRS = 2'b11
    } cmp_mode_e;
endpackage

// File: rtl/dvc_chan.sv
module dvc_chan
    import dvc_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  cmp_mode_e                 mode,
    input  logic [LANES-1:0]          ben,
    input  logic [LANES*BYTE_W-1:0]   val,
    input  logic [LANES-1:0]          strb,
    input  logic [LANES*BYTE_W-1:0]   data,
    output logic                      hit
);
    localparam int NGRP = LANES / 2;

    logic [LANES-1:0] eq_v;
    logic [LANES-1:0] ok_v;
    logic [NGRP-1:0]  grp_ok;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign eq_v[l] = data[l*BYTE_W +: BYTE_W] == val[l*BYTE_W +: BYTE_W];
        assign ok_v[l] = strb[l] && eq_v[l];
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_ok[g] = (ben[2*g +: 2] != 2'b00) &&
                           ((ok_v[2*g +: 2] & ben[2*g +: 2]) == ben[2*g +: 2]);
    end

    always_comb begin
        unique case (mode)
            CMP_ALL:   hit = (ben != '0) && ((ok_v & ben) == ben);
            CMP_ANY:   hit = |(ok_v & ben);
            CMP_PAIRS: hit = |grp_ok;
            default:   hit = 1'b0;
        endcase
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CMP_OFF) |-> !hit); // R1
    AST_ALL_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CMP_ALL && ben == '0) |-> !hit); // R3
    AST_ANY_NEEDS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CMP_ANY && hit) |-> ((ben & strb) != '0)); // R4
    AST_ALL_NEEDS_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CMP_ALL && hit) |-> ((strb & ben) == ben)); // R2
endmodule

// File: rtl/dvc_status.sv
module dvc_status #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set,
    input  logic [NUM_CH-1:0] clr,
    output logic [NUM_CH-1:0] stat
);
    typedef struct packed {
        logic [NUM_CH-1:0] stat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = (st_q.stat & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[c] && !clr[c]) |=> stat[c]); // R10
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[c] && !set[c]) |=> !stat[c]); // R11
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[c] |=> stat[c]); // R11
    end
endmodule

// File: rtl/dvc_unit.sv
module dvc_unit
    import dvc_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           acc_valid,
    input  logic                           acc_wr,
    input  logic                           acc_zero,
    input  logic                           acc_cond,
    input  logic                           acc_resv,
    input  logic [LANES-1:0]               acc_strb,
    input  logic [LANES*BYTE_W-1:0]        acc_data,
    input  logic [NUM_CH-1:0]              acc_addr_hit,
    input  logic [NUM_CH*2-1:0]            cfg_mode,
    input  logic [NUM_CH*LANES-1:0]        cfg_ben,
    input  logic [NUM_CH*LANES*BYTE_W-1:0] cfg_val,
    input  logic                           cfg_async,
    input  logic [NUM_CH-1:0]              stat_clr,
    output logic [NUM_CH-1:0]              evt_now,
    output logic [NUM_CH-1:0]              stat
);
    localparam int DATA_W = LANES * BYTE_W;

    logic [DATA_W-1:0] cmp_data;
    logic              acc_live;
    logic [NUM_CH-1:0] raw_hit;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] stat_set;

    always_comb begin
        cmp_data = acc_zero ? '0 : acc_data;
        acc_live = acc_valid && !(acc_wr && acc_cond && !acc_resv);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dvc_chan #(
            .LANES  (LANES),
            .BYTE_W (BYTE_W)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (cmp_mode_e'(cfg_mode[c*2 +: 2])),
            .ben   (cfg_ben[c*LANES +: LANES]),
            .val   (cfg_val[c*DATA_W +: DATA_W]),
            .strb  (acc_strb),
            .data  (cmp_data),
            .hit   (raw_hit[c])
        );
    end

    always_comb begin
        hit      = raw_hit & acc_addr_hit & {NUM_CH{acc_live}};
        evt_now  = cfg_async ? '0 : hit;
        stat_set = cfg_async ? hit : '0;
    end

    dvc_status #(.NUM_CH(NUM_CH)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (stat_set),
        .clr   (stat_clr),
        .stat  (stat)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (evt_now == '0)); // R6
    AST_QUAL_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_now & ~acc_addr_hit) == '0)); // R6
    AST_COND_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_cond && !acc_resv) |-> (evt_now == '0)); // R8
    AST_ASYNC_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_async |-> (evt_now == '0)); // R10
    AST_SYNC_STAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_async && stat_clr == '0) |=> $stable(stat)); // R9
endmodule

// File: tb/sim_dvc_unit.sv
module sim_dvc_unit;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_wr = 1'b0, acc_zero = 1'b0, acc_cond = 1'b0, acc_resv = 1'b0;
    logic [3:0]  acc_strb = '0;
    logic [31:0] acc_data = '0;
    logic [1:0]  acc_addr_hit = '0;
    logic [3:0]  cfg_mode = '0;
    logic [7:0]  cfg_ben = '0;
    logic [63:0] cfg_val = '0;
    logic        cfg_async = 1'b0;
    logic [1:0]  stat_clr = '0;
    logic [1:0]  evt_now, stat;

    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PER/2) clk = ~clk;

    dvc_unit u0 (.*);

    typedef struct packed {
        logic [1:0]  mode;
        logic [3:0]  ben;
        logic [31:0] val;
        logic [3:0]  strb;
        logic [31:0] data;
        logic        qual;
        logic        zero;
        logic        cond;
        logic        resv;
        logic        exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 4'hF, 32'hAABBCCDD, 4'hF, 32'hAABBCCDD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1},  // R1
        '{2'b01, 4'hF, 32'hAABBCCDD, 4'hF, 32'hAABBCCDD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd2},  // R2
        '{2'b01, 4'hF, 32'hAABBCCDD, 4'h7, 32'hAABBCCDD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 lane 3 not strobed
        '{2'b01, 4'h3, 32'hAABBCCDD, 4'h3, 32'h0000CCDD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd2},  // R2
        '{2'b01, 4'h3, 32'hAABBCCDD, 4'hF, 32'h0000CCDE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 lane 0 differs
        '{2'b01, 4'h0, 32'hAABBCCDD, 4'hF, 32'hAABBCCDD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3},  // R3
        '{2'b10, 4'h9, 32'hAABBCCDD, 4'h8, 32'hAA000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd4},  // R4
        '{2'b10, 4'h9, 32'hAABBCCDD, 4'h6, 32'hAABBCCDD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4},  // R4 only unmasked lanes
        '{2'b10, 4'hF, 32'hAABBCCDD, 4'hF, 32'h11111111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4},  // R4
        '{2'b11, 4'hF, 32'hAABBCCDD, 4'hC, 32'hAABB0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd5},  // R5 upper pair
        '{2'b11, 4'hF, 32'hAABBCCDD, 4'h3, 32'h0000CCDD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd5},  // R5 lower pair
        '{2'b11, 4'hF, 32'hAABBCCDD, 4'h6, 32'h00BBCC00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 straddle
        '{2'b11, 4'h3, 32'hAABBCCDD, 4'hC, 32'hAABB0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 empty group
        '{2'b01, 4'hF, 32'hAABBCCDD, 4'hF, 32'hAABBCCDD, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},  // R6
        '{2'b01, 4'hF, 32'h00000000, 4'hF, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd7},  // R7
        '{2'b01, 4'hF, 32'hAABBCCDD, 4'hF, 32'hAABBCCDD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd7},  // R7
        '{2'b01, 4'hF, 32'hAABBCCDD, 4'hF, 32'hAABBCCDD, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd8},  // R8
        '{2'b01, 4'hF, 32'hAABBCCDD, 4'hF, 32'hAABBCCDD, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd8},  // R8
        '{2'b10, 4'h4, 32'h00BB0000, 4'h4, 32'h00BB0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd7}   // R7
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_cond = 1'b0; acc_resv = 1'b0; acc_zero = 1'b0;
        stat_clr = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R13 reset stat", stat, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R13 stat after release", stat, 2'b00);

        // table walk on channel 0, channel 1 off
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg_async = 1'b0;
            cfg_mode = {2'b00, VECS[i].mode};
            cfg_ben = {4'h0, VECS[i].ben};
            cfg_val = {32'h0, VECS[i].val};
            acc_valid = 1'b1; acc_wr = 1'b1;
            acc_strb = VECS[i].strb; acc_data = VECS[i].data;
            acc_addr_hit = {1'b1, VECS[i].qual};
            acc_zero = VECS[i].zero; acc_cond = VECS[i].cond; acc_resv = VECS[i].resv;
            #1;
            total++;
            if (evt_now !== {1'b0, VECS[i].exp}) begin
                bad++;
                $display("FAIL R%0d vec %0d act=%b exp=%b", VECS[i].req, i, evt_now, {1'b0, VECS[i].exp});
            end
        end
        check("R9 stat untouched in sync mode", stat, 2'b00);

        // R6 no valid
        @(negedge clk);
        cfg_mode = 4'b0101; cfg_ben = 8'hFF; cfg_val = {32'hAABBCCDD, 32'hAABBCCDD};
        acc_valid = 1'b0; acc_cond = 1'b0; acc_zero = 1'b0; acc_strb = 4'hF;
        acc_data = 32'hAABBCCDD; acc_addr_hit = 2'b11;
        #1;
        check("R6 no valid", evt_now, 2'b00);

        // R12 both channels on one access, different modes
        @(negedge clk);
        acc_valid = 1'b1;
        cfg_mode = 4'b1001; cfg_ben = 8'h1F; cfg_val = {32'h000000DD, 32'hAABBCCDD};
        #1;
        check("R12 both fire", evt_now, 2'b11);
        @(negedge clk);
        acc_data = 32'h123456DD;
        #1;
        check("R12 next access only ch1", evt_now, 2'b10);
        @(negedge clk);
        acc_data = 32'hAABBCCDD;
        #1;
        check("R12 back-to-back own event", evt_now, 2'b11);

        // R10 asynchronous reporting
        @(negedge clk);
        cfg_async = 1'b1; cfg_mode = 4'b0001; acc_addr_hit = 2'b01;
        #1;
        check("R10 no pulse in async", evt_now, 2'b00);
        check("R10 stat before edge", stat, 2'b00);
        idle();
        #1;
        check("R10 stat set after edge", stat, 2'b01);
        idle(); idle();
        #1;
        check("R10 stat sticky", stat, 2'b01);

        // R11 clear
        @(negedge clk);
        stat_clr = 2'b01;
        #1;
        check("R11 stat before clear edge", stat, 2'b01);
        idle();
        #1;
        check("R11 cleared", stat, 2'b00);

        // R11 set beats clear
        @(negedge clk);
        acc_valid = 1'b1; acc_wr = 1'b1; stat_clr = 2'b01;
        idle();
        #1;
        check("R11 set wins over clear", stat, 2'b01);

        // R9 sync mode leaves stat and pulses
        @(negedge clk);
        cfg_async = 1'b0; acc_valid = 1'b1;
        #1;
        check("R9 pulse same cycle", evt_now, 2'b01);
        idle();
        #1;
        check("R9 pulse gone when idle", evt_now, 2'b00);
        check("R9 stat unchanged", stat, 2'b01);

        finish_run();
    end
endmodule